// File: doc/BRIEF.md
# Pattern RAM Indirect Register Window

This block lets a host reach a 128-word, 40-bit pattern store through two 32-bit registers. The lower register (offset 0x190) holds a 7-bit word pointer and the three lower data bytes. The upper register (offset 0x194) holds the two top data bytes. Writing the lower register only stages the pointer and bytes. Writing the upper register puts all five bytes into the pointed word in one RAM write, so a match engine never sees a half-written pattern.

Reading either register returns the contents of the word under the current pointer. The data comes from a synchronous RAM read and arrives one cycle after the read strobe. A match-mode input gives the RAM to an external matching engine. That engine drives its own word address and gets 40-bit data back on a separate port. While match mode is set, the host cannot change anything and host reads return zero.

Top module: `pattern_ram_window`

## Requirements
- R1: While reset is asserted and after reset is released, `host_rvalid`, `host_rdata` and `mt_rdata` are zero. The staged pointer and staged bytes are zero.
- R2: A host write to the lower register (offset 0x190) with match mode off stages the pointer from bits 6:0 and the data bytes 0, 1 and 2 from bits 15:8, 23:16 and 31:24. It does not change any RAM word.
- R3: A host write to the upper register (offset 0x194) with match mode off writes one 40-bit word at the staged pointer. Bits 23:0 of that word are staged bytes 0..2. Bits 31:24 come from write data bits 7:0, and bits 39:32 come from write data bits 15:8.
- R4: A host read of the lower register returns, in bits 31:8, word bits 23:0 of the RAM word at the staged pointer. Bit 7 is zero and bits 6:0 are the staged pointer.
- R5: A host read of the upper register returns word bits 39:24 in bits 15:0. Bits 31:16 are zero.
- R6: Every host read strobe is answered with `host_rvalid` high exactly one cycle later. Reads may be issued back to back and in either register order. `host_rdata` is zero whenever `host_rvalid` is low.
- R7: While match mode is set, host writes to either register change neither the staged state nor the RAM.
- R8: A host read issued while match mode is set returns zero.
- R9: While match mode is set, `mt_rdata` carries the RAM word at `mt_addr` one cycle after the address is presented. In the cycle after match mode was off, `mt_rdata` is zero.
- R10: Host writes to any other offset have no effect, and host reads of any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| match_mode | input | 1 | 1: RAM belongs to the match engine, host locked out |
| host_wr_en | input | 1 | Host register write strobe |
| host_rd_en | input | 1 | Host register read strobe |
| host_ofs | input | 9 | Host register byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd_en |
| mt_addr | input | 7 | Match engine word address |
| mt_rdata | output | 40 | Match engine read data, one cycle after mt_addr |

## Verification
A host write changes the staged pointer and the RAM at the clock edge where it is sampled. A read strobe is answered after the next edge, and a match-engine address produces data after the next edge, because both pass through the single RAM output register. The bench reference model evaluates each rising edge in read-before-write order and holds its predicted outputs for the following cycle. It compares them with the design at the falling edge, when outputs have settled and inputs are changing. A pointer written in one cycle is therefore seen by a read in the next cycle and shows up in the data one cycle after that, with no extra waiting in the bench.

// File: rtl/pram_pkg.sv
package pram_pkg;
  localparam int unsigned WORD_AW    = 7;
  localparam int unsigned WORD_BYTES = 5;
  localparam int unsigned WORD_W     = WORD_BYTES * 8;
  localparam int unsigned LO_BYTES   = 3;
  localparam int unsigned LO_W       = LO_BYTES * 8;
  localparam int unsigned HI_W       = WORD_W - LO_W;
  localparam int unsigned BUS_W      = 32;

  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_LO   = 2'd1,
    RSEL_HI   = 2'd2,
    RSEL_ZERO = 2'd3
  } rsel_e;
endpackage

// File: rtl/pram_decode.sv
module pram_decode
  import pram_pkg::*;
#(
  parameter int unsigned     OFS_W  = 9,
  parameter logic [OFS_W-1:0] LO_OFS = 9'h190,
  parameter logic [OFS_W-1:0] HI_OFS = 9'h194
) (
  input  logic             match_mode,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [OFS_W-1:0] ofs,
  output logic             wr_lo,
  output logic             wr_hi,
  output rsel_e            rsel
);
  logic hit_lo, hit_hi;

  always_comb begin
    hit_lo = (ofs == LO_OFS);
    hit_hi = (ofs == HI_OFS);
    wr_lo  = wr_en && !match_mode && hit_lo;
    wr_hi  = wr_en && !match_mode && hit_hi;
    if (!rd_en)          rsel = RSEL_NONE;
    else if (match_mode) rsel = RSEL_ZERO;
    else if (hit_lo)     rsel = RSEL_LO;
    else if (hit_hi)     rsel = RSEL_HI;
    else                 rsel = RSEL_ZERO;
  end

  always_comb begin
    AST_DECODE_EXCLUSIVE: assert (!(wr_lo && wr_hi)); // R3
  end
endmodule

// File: rtl/pram_stage.sv
module pram_stage
  import pram_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [BUS_W-1:0]   wdata,
  output logic [WORD_AW-1:0] st_addr,
  output logic               ram_we,
  output logic [WORD_AW-1:0] ram_waddr,
  output logic [WORD_W-1:0]  ram_wdata
);
  logic [WORD_AW-1:0] addr_q, addr_d;
  logic [LO_W-1:0]    lo_q, lo_d;

  always_comb begin
    addr_d = addr_q;
    lo_d   = lo_q;
    if (wr_lo) begin
      addr_d = wdata[WORD_AW-1:0];
      lo_d   = wdata[BUS_W-1:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      lo_q   <= '0;
    end else if (wr_lo) begin
      addr_q <= addr_d;
      lo_q   <= lo_d;
    end
  end

  always_comb begin
    st_addr   = addr_q;
    ram_we    = wr_hi;
    ram_waddr = addr_q;
    ram_wdata = {wdata[HI_W-1:0], lo_q};
  end

  AST_PTR_HELD_WITHOUT_LO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lo |=> $stable(addr_q)); // R2
  AST_STAGE_HELD_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo) |=> $stable(lo_q)); // R3
endmodule

// File: rtl/pram_array.sv
module pram_array
  import pram_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [WORD_AW-1:0] waddr,
  input  logic [WORD_W-1:0]  wdata,
  input  logic               re,
  input  logic [WORD_AW-1:0] raddr,
  output logic [WORD_W-1:0]  rdata
);
  localparam int unsigned DEPTH = 1 << WORD_AW;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] q_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_q <= '0;
    else if (re) q_q <= mem[raddr];
  end

  assign rdata = q_q;
endmodule

// File: rtl/pattern_ram_window.sv
module pattern_ram_window
  import pram_pkg::*;
#(
  parameter int unsigned      OFS_W  = 9,
  parameter logic [OFS_W-1:0] LO_OFS = 9'h190,
  parameter logic [OFS_W-1:0] HI_OFS = 9'h194
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               match_mode,
  input  logic               host_wr_en,
  input  logic               host_rd_en,
  input  logic [OFS_W-1:0]   host_ofs,
  input  logic [BUS_W-1:0]   host_wdata,
  output logic [BUS_W-1:0]   host_rdata,
  output logic               host_rvalid,
  input  logic [WORD_AW-1:0] mt_addr,
  output logic [WORD_W-1:0]  mt_rdata
);
  localparam int unsigned PAD_W = 8 - WORD_AW;

  logic               wr_lo, wr_hi;
  rsel_e              rsel, rsel_q;
  logic [WORD_AW-1:0] st_addr, ram_waddr, ram_raddr, raddr_q;
  logic               ram_we, ram_re;
  logic [WORD_W-1:0]  ram_wdata, ram_q;
  logic               mode_q;

  pram_decode #(.OFS_W(OFS_W), .LO_OFS(LO_OFS), .HI_OFS(HI_OFS)) i_decode (
    .match_mode (match_mode),
    .wr_en      (host_wr_en),
    .rd_en      (host_rd_en),
    .ofs        (host_ofs),
    .wr_lo      (wr_lo),
    .wr_hi      (wr_hi),
    .rsel       (rsel)
  );

  pram_stage i_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi),
    .wdata     (host_wdata),
    .st_addr   (st_addr),
    .ram_we    (ram_we),
    .ram_waddr (ram_waddr),
    .ram_wdata (ram_wdata)
  );

  always_comb begin
    ram_raddr = match_mode ? mt_addr : st_addr;
    ram_re    = match_mode || host_rd_en;
  end

  pram_array i_array (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .re    (ram_re),
    .raddr (ram_raddr),
    .rdata (ram_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsel_q  <= RSEL_NONE;
      raddr_q <= '0;
      mode_q  <= 1'b0;
    end else begin
      rsel_q <= rsel;
      mode_q <= match_mode;
      if (host_rd_en) raddr_q <= st_addr;
    end
  end

  always_comb begin
    host_rvalid = (rsel_q != RSEL_NONE);
    unique case (rsel_q)
      RSEL_LO: host_rdata = {ram_q[LO_W-1:0], {PAD_W{1'b0}}, raddr_q};
      RSEL_HI: host_rdata = {{(BUS_W-HI_W){1'b0}}, ram_q[WORD_W-1:LO_W]};
      default: host_rdata = '0;
    endcase
    mt_rdata = mode_q ? ram_q : '0;
  end

  AST_RVALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_en |=> host_rvalid); // R6
  AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd_en |=> !host_rvalid); // R6
  AST_NO_RAM_WRITE_IN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    match_mode |-> !ram_we); // R7
  AST_BLANK_HOST_READ_IN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_en && match_mode) |=> (host_rdata == '0)); // R8
  AST_MT_QUIET_IN_HOST_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !match_mode |=> (mt_rdata == '0)); // R9
  AST_RESERVED_BIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_en && !match_mode && host_ofs == LO_OFS) |=> !host_rdata[7]); // R4
endmodule

// File: tb/test_pattern_ram_window.sv
module test_pattern_ram_window;
  localparam int CLK_PERIOD = 10;
  localparam logic [8:0] OFS_LO  = 9'h190;
  localparam logic [8:0] OFS_HI  = 9'h194;
  localparam logic [8:0] OFS_BAD = 9'h198;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        match_mode = 1'b0;
  logic        host_wr_en = 1'b0;
  logic        host_rd_en = 1'b0;
  logic [8:0]  host_ofs = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_rvalid;
  logic [6:0]  mt_addr = '0;
  logic [39:0] mt_rdata;

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // reference model state
  logic [39:0] ref_mem [128];
  logic [6:0]  ref_ptr;
  logic [23:0] ref_lo;
  logic [31:0] exp_rdata;
  logic        exp_rvalid;
  logic [39:0] exp_mt;

  pattern_ram_window i_pattern_ram_window (
    .clk(clk), .rst_n(rst_n), .match_mode(match_mode),
    .host_wr_en(host_wr_en), .host_rd_en(host_rd_en), .host_ofs(host_ofs),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .mt_addr(mt_addr), .mt_rdata(mt_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [39:0] pat(input int i);
    return {8'(i * 7 + 3), 8'(i ^ 8'h5A), 8'(i + 8'h11), 8'(~i), 8'(i * 3)};
  endfunction

  // behavioural model: read before write, evaluated each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_ptr = '0; ref_lo = '0;
      exp_rdata = '0; exp_rvalid = 1'b0; exp_mt = '0;
    end else begin
      logic [39:0] word;
      word = ref_mem[match_mode ? mt_addr : ref_ptr];
      exp_mt = match_mode ? word : 40'd0;
      exp_rvalid = host_rd_en;
      exp_rdata = 32'd0;
      if (host_rd_en && !match_mode) begin
        if (host_ofs == OFS_LO) exp_rdata = {word[23:0], 1'b0, ref_ptr};
        else if (host_ofs == OFS_HI) exp_rdata = {16'd0, word[39:24]};
      end
      if (host_wr_en && !match_mode) begin
        if (host_ofs == OFS_LO) begin
          ref_ptr = host_wdata[6:0];
          ref_lo  = host_wdata[31:8];
        end else if (host_ofs == OFS_HI) begin
          ref_mem[ref_ptr] = {host_wdata[15:0], ref_lo};
        end
      end
    end
  end

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(cur_req, "rvalid", 64'(host_rvalid), 64'(exp_rvalid));
      if (exp_rvalid || !host_rvalid) check(cur_req, "rdata", 64'(host_rdata), 64'(exp_rdata));
      check(cur_req, "mt_rdata", 64'(mt_rdata), 64'(exp_mt));
    end
  end

  task automatic wr(input logic [8:0] o, input logic [31:0] d);
    host_wr_en = 1'b1; host_ofs = o; host_wdata = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [8:0] o);
    host_rd_en = 1'b1; host_ofs = o;
    @(negedge clk);
    host_rd_en = 1'b0;
  endtask

  task automatic put_word(input logic [6:0] a, input logic [39:0] w);
    wr(OFS_LO, {w[23:0], 1'b0, a});
    wr(OFS_HI, {16'd0, w[39:24]});
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 128; i++) ref_mem[i] = '0;
    cur_req = "R1";
    repeat (3) @(negedge clk);
    check("R1", "reset rdata", 64'(host_rdata), 64'd0);
    check("R1", "reset rvalid", 64'(host_rvalid), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3: fill every word through the atomic commit
    cur_req = "R3";
    for (int i = 0; i < 128; i++) put_word(7'(i), pat(i));

    // R4, R5: read back through both registers in either order
    cur_req = "R4";
    wr(OFS_LO, {24'd0, 8'h05});
    rd(OFS_LO);
    cur_req = "R5";
    rd(OFS_HI);
    cur_req = "R6";
    rd(OFS_HI); rd(OFS_LO); rd(OFS_HI);
    @(negedge clk);

    // R2: staging the lower register leaves RAM untouched; bit 7 ignored
    cur_req = "R2";
    wr(OFS_LO, 32'hDEADBE89);
    rd(OFS_LO); rd(OFS_HI);
    check("R2", "word 9 untouched hi", 64'(host_rdata), 64'({16'd0, pat(9)[39:24]}));

    // R3: commit then read back the new word
    cur_req = "R3";
    wr(OFS_HI, 32'hFFFF_C0DE);
    rd(OFS_HI); rd(OFS_LO);
    check("R3", "committed lo", 64'(host_rdata), 64'({24'hDEADBE, 8'h09}));

    // R10: other offsets ignored
    cur_req = "R10";
    wr(OFS_BAD, 32'h1234_5678);
    rd(OFS_BAD);
    check("R10", "bad offset read", 64'(host_rdata), 64'd0);
    rd(OFS_LO);

    // R7, R8, R9: match mode
    cur_req = "R9";
    match_mode = 1'b1;
    for (int i = 0; i < 10; i++) begin
      mt_addr = 7'(i * 13);
      @(negedge clk);
    end
    cur_req = "R7";
    wr(OFS_LO, 32'hAAAA_AA11);
    wr(OFS_HI, 32'h0000_BBBB);
    cur_req = "R8";
    rd(OFS_LO); rd(OFS_HI);
    check("R8", "blank read", 64'(host_rdata), 64'd0);
    mt_addr = 7'd9;
    @(negedge clk);
    check("R9", "mt word 9", 64'(mt_rdata), 64'({16'hC0DE, 24'hDEADBE}));
    match_mode = 1'b0;
    @(negedge clk);
    cur_req = "R7";
    rd(OFS_LO);
    check("R7", "ptr kept after match writes", 64'(host_rdata), 64'({24'hDEADBE, 8'h09}));
    wr(OFS_LO, 32'h0000_0011);
    rd(OFS_LO);
    check("R7", "word 0x11 untouched", 64'(host_rdata), 64'({pat(17)[23:0], 8'h11}));
    rd(OFS_HI);
    check("R7", "word 0x11 hi untouched", 64'(host_rdata), 64'({16'd0, pat(17)[39:24]}));

    // R6: long back-to-back read burst
    cur_req = "R6";
    host_rd_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      host_ofs = i[0] ? OFS_HI : OFS_LO;
      @(negedge clk);
    end
    host_rd_en = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule